// File: doc/BRIEF.md
# Memory BAR Decode Window Tracker

This block holds the live address decode window of each memory base address register (BAR) of a device function. It tells the surrounding fabric which window, if any, claims an incoming address. It watches two kinds of event from the configuration register file: writes to the command register, from which only the memory-space enable bit is taken, and BAR dword writes. From these it keeps a per-window tracking flag, so that a window whose base is stale or unassigned never decodes.

Each BAR occupies a lower and an upper dword. The window base comes from the stored dwords and the window end is the base plus the BAR's fixed power-of-two size, minus one. Lookups need no handshake. The address and its valid strobe go in, the per-BAR hit vector comes back in the same cycle, and the lookup side never applies back-pressure. Configuration events are single-cycle strobes and are never stalled.

Top module: `bar_window_tracker`

## Requirements
- R1: After reset or a `reinit_i` pulse, every tracking flag is 0, memory enable is 0 and every stored BAR dword is 0.
- R2: A command write with `cmd_mem_en_i` = 1 while memory enable is 0 sets every tracking flag one cycle later. A command write with 0 while memory enable is 1 clears every tracking flag one cycle later.
- R3: A command write whose enable value equals the current memory enable changes no tracking flag, even if a flag was cleared by an earlier sizing write.
- R4: A BAR write whose data is not all ones stores the dword one cycle later. The dword goes to the upper half when `bar_wr_upper_i` = 1 and to the lower half otherwise. The flag of that BAR then equals the current memory enable: the old window is dropped, and the new one is tracked only if memory enable is on.
- R5: A BAR write of 0xFFFFFFFF (a sizing write) clears that BAR's tracking flag. It stores the low 32 bits of ~(size-1) to a lower dword. To an upper dword it stores the high 32 bits of ~(size-1) if the lower dword's bit 2 is 1, and 0 otherwise.
- R6: Bit 2 of the lower dword marks a 64-bit BAR, whose base is {upper, lower}; otherwise the base is the lower dword zero-extended. Bits 3:0 of the base always read as 0.
- R7: A window covers base to base + 2^BAR_SIZE_LOG2[i] - 1, with both ends inclusive.
- R8: `hit_o[i]` is 1 in the same cycle exactly when `lkp_vld_i` = 1, BAR i is tracked and the address lies in its window. No hit is possible while the lookup valid is low.
- R9: A BAR write whose select is NUM_BARS or above changes no flag and no stored dword.
- R10: When a command write that changes memory enable and a BAR write fall in the same cycle, the BAR data is stored and every flag takes the new enable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reinit_i | input | 1 | Synchronous re-initialisation strobe |
| cmd_wr_i | input | 1 | Command register write strobe |
| cmd_mem_en_i | input | 1 | Memory-space enable bit of the command write |
| bar_wr_i | input | 1 | BAR dword write strobe |
| bar_wr_sel_i | input | IDX_W | BAR index of the write |
| bar_wr_upper_i | input | 1 | 1 = upper dword, 0 = lower dword |
| bar_wr_data_i | input | 32 | Written dword |
| lkp_vld_i | input | 1 | Lookup address valid |
| lkp_addr_i | input | 64 | Lookup address |
| hit_o | output | NUM_BARS | Per-BAR window hit, combinational |
| tracked_o | output | NUM_BARS | Per-BAR tracking flags |
| mem_en_o | output | 1 | Registered memory enable |

## Verification
Flag and memory-enable updates from a strobe sampled at one rising edge appear at that same edge. The bench therefore compares `tracked_o` and `mem_en_o` a quarter period after every rising edge, against a model advanced at the same edge. Hits are combinational on the registered windows. They are compared in the same quarter-period slot, and directed probes are read mid-way through the low phase, after the address is changed on a falling edge. Window contents written by one strobe are probed no earlier than the cycle after it.

// File: rtl/bwt_pkg.sv
package bwt_pkg;
  localparam int ADDR_W  = 64;
  localparam int DWORD_W = 32;
  localparam int TYPE64_BIT = 2;
  localparam int FLAG_BITS  = 4;

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [DWORD_W-1:0] dword_t;

  typedef struct packed {
    dword_t upper;
    dword_t lower;
  } bar_pair_t;

  function automatic addr_t window_base(bar_pair_t b);
    addr_t raw;
    raw = b.lower[TYPE64_BIT] ? {b.upper, b.lower} : {{DWORD_W{1'b0}}, b.lower};
    return {raw[ADDR_W-1:FLAG_BITS], {FLAG_BITS{1'b0}}};
  endfunction
endpackage

// File: rtl/bwt_mem_enable.sv
module bwt_mem_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic reinit_i,
  input  logic cmd_wr_i,
  input  logic cmd_mem_en_i,
  output logic mem_en_o,
  output logic change_o,
  output logic change_val_o
);
  logic en_q;

  // Only a real transition of the enable bit is reported.
  assign change_o     = cmd_wr_i && (cmd_mem_en_i != en_q);
  assign change_val_o = cmd_mem_en_i;
  assign mem_en_o     = en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= 1'b0;
    else if (reinit_i) en_q <= 1'b0;
    else if (change_o) en_q <= cmd_mem_en_i;
  end
endmodule

// File: rtl/bwt_window.sv
module bwt_window
  import bwt_pkg::*;
#(
  parameter int SIZE_LOG2 = 12
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   reinit_i,
  input  logic   wr_i,
  input  logic   wr_upper_i,
  input  dword_t wr_data_i,
  input  logic   mem_en_i,
  input  logic   change_i,
  input  logic   change_val_i,
  input  logic   lkp_vld_i,
  input  addr_t  lkp_addr_i,
  output logic   tracked_o,
  output logic   hit_o
);
  localparam addr_t SIZE      = addr_t'(1) << SIZE_LOG2;
  localparam addr_t SIZE_MASK = ~(SIZE - addr_t'(1));

  bar_pair_t regs_q;
  logic      trk_q, trk_nxt;
  logic      sizing;
  addr_t     base, last;

  assign sizing = (wr_data_i == '1);

  // Old window is always dropped on a rewrite; a command edge overrides.
  always_comb begin
    trk_nxt = trk_q;
    if (wr_i)     trk_nxt = sizing ? 1'b0 : mem_en_i;
    if (change_i) trk_nxt = change_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
      trk_q  <= 1'b0;
    end else if (reinit_i) begin
      regs_q <= '0;
      trk_q  <= 1'b0;
    end else begin
      if (wr_i) begin
        if (wr_upper_i) begin
          if (sizing)
            regs_q.upper <= regs_q.lower[TYPE64_BIT] ? SIZE_MASK[ADDR_W-1:DWORD_W] : '0;
          else
            regs_q.upper <= wr_data_i;
        end else begin
          regs_q.lower <= sizing ? SIZE_MASK[DWORD_W-1:0] : wr_data_i;
        end
      end
      trk_q <= trk_nxt;
    end
  end

  assign base      = window_base(regs_q);
  assign last      = base + SIZE - addr_t'(1);
  assign tracked_o = trk_q;
  assign hit_o     = lkp_vld_i && trk_q && (lkp_addr_i >= base) && (lkp_addr_i <= last);
endmodule

// File: rtl/bar_window_tracker.sv
module bar_window_tracker
  import bwt_pkg::*;
#(
  parameter int NUM_BARS = 3,
  parameter logic [8*NUM_BARS-1:0] BAR_SIZE_LOG2 = {8'd20, 8'd16, 8'd12},
  localparam int IDX_W = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reinit_i,
  input  logic                cmd_wr_i,
  input  logic                cmd_mem_en_i,
  input  logic                bar_wr_i,
  input  logic [IDX_W-1:0]    bar_wr_sel_i,
  input  logic                bar_wr_upper_i,
  input  logic [31:0]         bar_wr_data_i,
  input  logic                lkp_vld_i,
  input  logic [63:0]         lkp_addr_i,
  output logic [NUM_BARS-1:0] hit_o,
  output logic [NUM_BARS-1:0] tracked_o,
  output logic                mem_en_o
);
  logic mem_en, change, change_val;

  bwt_mem_enable u_en (
    .clk          (clk),
    .rst_n        (rst_n),
    .reinit_i     (reinit_i),
    .cmd_wr_i     (cmd_wr_i),
    .cmd_mem_en_i (cmd_mem_en_i),
    .mem_en_o     (mem_en),
    .change_o     (change),
    .change_val_o (change_val)
  );

  assign mem_en_o = mem_en;

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_win
    localparam int SL = int'(BAR_SIZE_LOG2[8*g +: 8]);
    logic sel;
    assign sel = bar_wr_i && (int'(bar_wr_sel_i) == g);

    bwt_window #(.SIZE_LOG2(SL)) u_win (
      .clk          (clk),
      .rst_n        (rst_n),
      .reinit_i     (reinit_i),
      .wr_i         (sel),
      .wr_upper_i   (bar_wr_upper_i),
      .wr_data_i    (bar_wr_data_i),
      .mem_en_i     (mem_en),
      .change_i     (change),
      .change_val_i (change_val),
      .lkp_vld_i    (lkp_vld_i),
      .lkp_addr_i   (lkp_addr_i),
      .tracked_o    (tracked_o[g]),
      .hit_o        (hit_o[g])
    );
  end
endmodule

// File: rtl/bwt_checker.sv
module bwt_checker #(
  parameter int NUM_BARS = 3,
  parameter int IDX_W = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reinit_i,
  input logic                cmd_wr_i,
  input logic                cmd_mem_en_i,
  input logic                bar_wr_i,
  input logic [IDX_W-1:0]    bar_wr_sel_i,
  input logic [31:0]         bar_wr_data_i,
  input logic                lkp_vld_i,
  input logic [NUM_BARS-1:0] hit_o,
  input logic [NUM_BARS-1:0] tracked_o,
  input logic                mem_en_o
);
  logic wr_ok;
  assign wr_ok = bar_wr_i && (int'(bar_wr_sel_i) < NUM_BARS);

  // R1
  reinit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_i |=> (tracked_o == '0) && !mem_en_o);

  // R2
  mem_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_i && cmd_mem_en_i && !mem_en_o && !reinit_i) |=> (&tracked_o));

  // R2
  mem_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_i && !cmd_mem_en_i && mem_en_o && !reinit_i) |=> (tracked_o == '0));

  // R3
  same_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_i && (cmd_mem_en_i == mem_en_o) && !bar_wr_i && !reinit_i) |=> $stable(tracked_o));

  // R4
  rewrite_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && (bar_wr_data_i != '1) && !cmd_wr_i && !reinit_i)
      |=> (tracked_o[$past(bar_wr_sel_i)] == $past(mem_en_o)));

  // R5
  sizing_untrack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && (bar_wr_data_i == '1) && !cmd_wr_i && !reinit_i)
      |=> !tracked_o[$past(bar_wr_sel_i)]);

  // R8
  hit_needs_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o & ~tracked_o) == '0);

  // R8
  hit_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_vld_i |-> (hit_o == '0));
endmodule

bind bar_window_tracker bwt_checker #(.NUM_BARS(NUM_BARS), .IDX_W(IDX_W)) u_bwt_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reinit_i      (reinit_i),
  .cmd_wr_i      (cmd_wr_i),
  .cmd_mem_en_i  (cmd_mem_en_i),
  .bar_wr_i      (bar_wr_i),
  .bar_wr_sel_i  (bar_wr_sel_i),
  .bar_wr_data_i (bar_wr_data_i),
  .lkp_vld_i     (lkp_vld_i),
  .hit_o         (hit_o),
  .tracked_o     (tracked_o),
  .mem_en_o      (mem_en_o)
);

// File: tb/test_bar_window_tracker.sv
`timescale 1ns/1ps
module test_bar_window_tracker;
  localparam int  CLK_PERIOD = 10;
  localparam int  N = 3;
  localparam int  IW = 2;
  localparam int  SZL [N] = '{12, 16, 20};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reinit = 1'b0, cmd_wr = 1'b0, cmd_en = 1'b0;
  logic bar_wr = 1'b0, bar_up = 1'b0, lkp_vld = 1'b0;
  logic [IW-1:0] bar_sel = '0;
  logic [31:0] bar_data = '0;
  logic [63:0] lkp_addr = '0;
  logic [N-1:0] hit, trk;
  logic mem_en;

  int checks = 0, errors = 0;
  string phase = "R1";

  // behavioural reference
  logic [31:0] m_lo [N];
  logic [31:0] m_hi [N];
  bit m_trk [N];
  bit m_en;

  bar_window_tracker i_bar_window_tracker (
    .clk(clk), .rst_n(rst_n), .reinit_i(reinit), .cmd_wr_i(cmd_wr),
    .cmd_mem_en_i(cmd_en), .bar_wr_i(bar_wr), .bar_wr_sel_i(bar_sel),
    .bar_wr_upper_i(bar_up), .bar_wr_data_i(bar_data), .lkp_vld_i(lkp_vld),
    .lkp_addr_i(lkp_addr), .hit_o(hit), .tracked_o(trk), .mem_en_o(mem_en));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [N-1:0] model_hit();
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++) begin
      longint unsigned b, sz;
      sz = 64'd1 << SZL[i];
      b = m_lo[i][2] ? {m_hi[i], m_lo[i]} : {32'd0, m_lo[i]};
      b = b & ~64'hF;
      r[i] = lkp_vld && m_trk[i] && (lkp_addr >= b) && (lkp_addr <= b + sz - 1);
    end
    return r;
  endfunction

  function automatic logic [N-1:0] model_trk();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = m_trk[i];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || reinit) begin
      for (int i = 0; i < N; i++) begin m_lo[i] = 0; m_hi[i] = 0; m_trk[i] = 0; end
      m_en = 0;
    end else begin
      if (bar_wr && int'(bar_sel) < N) begin
        longint unsigned msk;
        msk = ~((64'd1 << SZL[bar_sel]) - 1);
        if (bar_data == 32'hFFFF_FFFF) begin
          if (bar_up) m_hi[bar_sel] = m_lo[bar_sel][2] ? msk[63:32] : 32'd0;
          else        m_lo[bar_sel] = msk[31:0];
          m_trk[bar_sel] = 0;
        end else begin
          if (bar_up) m_hi[bar_sel] = bar_data; else m_lo[bar_sel] = bar_data;
          m_trk[bar_sel] = m_en;
        end
      end
      if (cmd_wr && cmd_en != m_en) begin
        m_en = cmd_en;
        for (int i = 0; i < N; i++) m_trk[i] = cmd_en;
      end
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      check(phase, 64'(trk), 64'(model_trk()), "tracked");
      check(phase, 64'(mem_en), 64'(m_en), "mem_en");
      check(phase, 64'(hit), 64'(model_hit()), "hit");
    end
  end

  task automatic cmd(bit v);
    @(negedge clk); cmd_wr = 1; cmd_en = v;
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic barw(int sel, bit up, logic [31:0] d);
    @(negedge clk); bar_wr = 1; bar_sel = IW'(sel); bar_up = up; bar_data = d;
    @(negedge clk); bar_wr = 0;
  endtask

  task automatic probe(string req, logic [63:0] a, bit v, logic [N-1:0] exp);
    @(negedge clk); lkp_addr = a; lkp_vld = v;
    #1 check(req, 64'(hit), 64'(exp), "probe hit");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    phase = "R1";
    check("R1", 64'(trk), 0, "tracked after reset");
    check("R1", 64'(mem_en), 0, "mem_en after reset");
    probe("R1", 64'h0, 1, 3'b000);

    phase = "R4";
    barw(0, 0, 32'h8000_0000);
    check("R4", 64'(trk), 0, "rewrite while disabled");
    phase = "R2";
    cmd(1);
    check("R2", 64'(trk), 3'b111, "rise tracks all");
    phase = "R7";
    probe("R7", 64'h8000_0000, 1, 3'b001);
    probe("R7", 64'h8000_0FFF, 1, 3'b001);
    probe("R7", 64'h8000_1000, 1, 3'b000);
    phase = "R8";
    probe("R8", 64'h8000_0010, 0, 3'b000);

    phase = "R6";
    barw(1, 1, 32'h0000_0001);
    barw(1, 0, 32'h4000_000C);
    check("R4", 64'(trk), 3'b111, "rewrite while enabled");
    probe("R6", 64'h1_4000_0000, 1, 3'b010);
    probe("R6", 64'h1_4000_FFFF, 1, 3'b010);
    probe("R6", 64'h0_4000_0000, 1, 3'b000);

    phase = "R5";
    barw(2, 0, 32'hFFFF_FFFF);
    check("R5", 64'(trk), 3'b011, "sizing untracks");
    phase = "R3";
    cmd(1);
    check("R3", 64'(trk), 3'b011, "same enable no effect");
    phase = "R2";
    cmd(0);
    check("R2", 64'(trk), 3'b000, "fall untracks all");
    cmd(0);
    check("R3", 64'(trk), 3'b000, "repeat disable");
    cmd(1);
    phase = "R5";
    probe("R5", 64'hFFF0_0000, 1, 3'b100);
    probe("R5", 64'hFFEF_FFFF, 1, 3'b000);
    barw(1, 1, 32'hFFFF_FFFF);
    probe("R5", 64'h1_4000_0000, 1, 3'b000);

    phase = "R9";
    barw(3, 0, 32'h1234_0000);
    check("R9", 64'(trk), 3'b101, "out of range select");
    probe("R9", 64'h8000_0004, 1, 3'b001);

    phase = "R10";
    @(negedge clk);
    cmd_wr = 1; cmd_en = 0; bar_wr = 1; bar_sel = 0; bar_up = 0; bar_data = 32'h2000_0000;
    @(negedge clk); cmd_wr = 0; bar_wr = 0;
    check("R10", 64'(trk), 3'b000, "edge wins same cycle");
    cmd(1);
    probe("R10", 64'h2000_0100, 1, 3'b001);

    phase = "R1";
    @(negedge clk); reinit = 1;
    @(negedge clk); reinit = 0;
    check("R1", 64'(trk), 0, "tracked after reinit");
    check("R1", 64'(mem_en), 0, "mem_en after reinit");
    cmd(1);
    probe("R1", 64'h0, 1, 3'b111);
    probe("R1", 64'h2000_0100, 1, 3'b000);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule